// File: doc/BRIEF.md
# USB IN Endpoint Transfer Tracker

This block follows a single device-side IN endpoint through one programmed transfer. Software first writes a byte total and a packet total into the transfer-size register, then sets the endpoint enable. From then on the core owns both counters. The byte total falls each time a packet is copied from memory into the transmit FIFO. The packet total falls each time a packet is drained from the FIFO toward the bus. When both totals reach zero, the block clears the enable and raises a completion flag.

The block also keeps a small write-1-to-clear interrupt status register. Its flags cover a software-requested disable, a memory-bus error, a bus timeout, an IN token that arrives while the FIFO is empty, and a NAK request that has taken effect. It has a read-only FIFO-empty indication, a mask register, and a single combined interrupt line.

A two-bit response code tells the bus side what to answer to the next IN token. Stall is answered first. NAK is answered when NAK is requested, when the endpoint is off, or when no packets remain. Otherwise the answer is data.

Top module: `usb_in_ep_tracker`

## Requirements
- R1: The transfer-size register (write address 1) holds the byte total in bits 6:0 and the packet total in bits 20:19. Every other bit reads as 0 and ignores writes.
- R2: While enabled, a load strobe reduces the byte total by `load_len`. When `load_len` is equal to or larger than the remaining total, the byte total becomes 0 and never wraps.
- R3: While enabled, a sent strobe reduces the packet total by one. At zero the packet total stays 0.
- R4: While the enable is set, writes to the transfer-size register change nothing, and writing 0 to the enable bit (control bit 0, address 0) does not clear it.
- R5: In the cycle after both totals are zero with the enable set, the enable clears and status bit 0 (transfer done) sets.
- R6: When the packet total is 0 but the byte total is not, the response code is NAK (2'b10) and the transfer stays enabled and incomplete.
- R7: Status bit 6 is read-only and reflects the FIFO level. With control bit 5 at 0 it is 1 when the level is at most half the FIFO depth. With control bit 5 at 1 it is 1 only when the level is 0. With the level at 0 it reads 1 after reset.
- R8: An IN token with FIFO level 0 sets status bit 4. A token with a non-zero level leaves it unchanged.
- R9: A timeout event sets status bit 3 and a bus-error event sets status bit 2. A control write with bit 4 while enabled clears the enable and sets status bit 1.
- R10: Control bit 1 requests NAK and control bit 3 withdraws it. Control bit 2 requests stall. Status bit 5 sets one cycle after a NAK request takes hold. Response codes are 2'b01 data, 2'b10 NAK and 2'b11 stall, and stall wins over NAK.
- R11: Writing 1 to a status bit 0 to 5 (address 2) clears it. A set event in the same cycle wins over the clear.
- R12: `int_line` is the OR of every status bit ANDed with the matching bit of the mask register (address 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 size, 2 status, 3 mask |
| wr_data | input | 32 | Register write data |
| load_stb | input | 1 | A packet was copied from memory into the FIFO |
| load_len | input | 7 | Byte length of that packet |
| sent_stb | input | 1 | A packet was drained from the FIFO to the bus |
| fifo_lvl | input | 6 | Current FIFO fill level in entries |
| in_token | input | 1 | IN token received for this endpoint |
| tmo_evt | input | 1 | Bus timeout on the last IN token |
| bus_err_evt | input | 1 | Memory-bus error during DMA |
| ep_enabled | output | 1 | Endpoint enable state |
| xfer_size_reg | output | 32 | Transfer-size register contents |
| int_status | output | 7 | Interrupt status register |
| int_line | output | 1 | Combined masked interrupt |
| ep_resp | output | 2 | Response code for the next IN token |

## Verification
The counters are driven with one transfer that mixes full loads, an oversized final load, sends that run ahead of and behind the loads, and strobes that arrive after a counter has hit zero. This separates the two counting events from each other and shows that each counter stops at zero. A second transfer runs out of packets first and has bytes left. It shows that completion waits for both counters, and that the response falls back to NAK meanwhile. Directed cases cover each level threshold of the FIFO-empty bit, tokens at zero and non-zero levels, a clear that lands in the same cycle as a set, and the order of stall and NAK.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

   typedef enum logic [1:0] {
      RESP_NONE  = 2'b00,
      RESP_DATA  = 2'b01,
      RESP_NAK   = 2'b10,
      RESP_STALL = 2'b11
   } ep_resp_e;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_SIZE = 2'd1;
   localparam logic [1:0] ADDR_STS  = 2'd2;
   localparam logic [1:0] ADDR_MASK = 2'd3;

   localparam int CTRL_W     = 6;
   localparam int CB_EN      = 0;
   localparam int CB_NAK_SET = 1;
   localparam int CB_STALL   = 2;
   localparam int CB_NAK_CLR = 3;
   localparam int CB_DIS     = 4;
   localparam int CB_LVL     = 5;

   localparam int NUM_FLAGS  = 6;
   localparam int STS_W      = NUM_FLAGS + 1;
   localparam int SB_DONE    = 0;
   localparam int SB_DIS     = 1;
   localparam int SB_BUSERR  = 2;
   localparam int SB_TMO     = 3;
   localparam int SB_TKN     = 4;
   localparam int SB_NAKEFF  = 5;
   localparam int SB_EMPTY   = 6;

endpackage

// File: rtl/usb_in_ep_counters.sv
module usb_in_ep_counters #(
   parameter int BYTE_W = 7,
   parameter int PKT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_load,
   input  logic [BYTE_W-1:0] sw_bytes,
   input  logic [PKT_W-1:0]  sw_pkts,
   input  logic              en_i,
   input  logic              load_stb,
   input  logic [BYTE_W-1:0] load_len,
   input  logic              sent_stb,
   output logic [BYTE_W-1:0] bytes_o,
   output logic [PKT_W-1:0]  pkts_o,
   output logic              done_o
);

   logic [BYTE_W-1:0] bytes_q;
   logic [PKT_W-1:0]  pkts_q;
   logic [BYTE_W-1:0] bytes_next;
   logic              pkts_zero;

   assign pkts_zero  = (pkts_q == '0);
   assign bytes_next = (load_len >= bytes_q) ? '0 : (bytes_q - load_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bytes_q <= '0;
         pkts_q  <= '0;
      end else if (sw_load && !en_i) begin
         bytes_q <= sw_bytes;
         pkts_q  <= sw_pkts;
      end else if (en_i) begin
         if (load_stb) bytes_q <= bytes_next;
         if (sent_stb && !pkts_zero) pkts_q <= pkts_q - 1'b1;
      end
   end

   assign bytes_o = bytes_q;
   assign pkts_o  = pkts_q;
   assign done_o  = en_i && (bytes_q == '0) && pkts_zero;

   AST_BYTE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> bytes_q <= $past(bytes_q));  // R2

   AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && sent_stb && !pkts_zero) |=> pkts_q == PKT_W'($past(pkts_q) - 1'b1));  // R3

   AST_PKT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && pkts_zero) |=> pkts_q == '0);  // R3

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
   import usb_in_ep_pkg::*;
#(
   parameter int SW = STS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_bits,
   input  logic              mask_wr,
   input  logic [SW-1:0]     mask_bits,
   input  logic              done_i,
   input  logic              pkt_zero_i,
   output logic              en_o,
   output logic              lvl_sel_o,
   output logic              dis_pulse_o,
   output logic              nak_eff_pulse_o,
   output logic [SW-1:0]     mask_o,
   output ep_resp_e          resp_o
);

   logic          en_q, nak_q, stall_q, sel_q, nak_seen_q;
   logic [SW-1:0] mask_q;

   assign dis_pulse_o = ctrl_wr && ctrl_bits[CB_DIS] && en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         nak_q      <= 1'b0;
         stall_q    <= 1'b0;
         sel_q      <= 1'b0;
         nak_seen_q <= 1'b0;
         mask_q     <= '0;
      end else begin
         if (done_i || dis_pulse_o)              en_q <= 1'b0;
         else if (ctrl_wr && ctrl_bits[CB_EN])   en_q <= 1'b1;
         if (ctrl_wr) begin
            stall_q <= ctrl_bits[CB_STALL];
            sel_q   <= ctrl_bits[CB_LVL];
            if (ctrl_bits[CB_NAK_SET])      nak_q <= 1'b1;
            else if (ctrl_bits[CB_NAK_CLR]) nak_q <= 1'b0;
         end
         nak_seen_q <= nak_q;
         if (mask_wr) mask_q <= mask_bits;
      end
   end

   assign nak_eff_pulse_o = nak_q && !nak_seen_q;

   always_comb begin
      if (stall_q)                              resp_o = RESP_STALL;
      else if (nak_q || !en_q || pkt_zero_i)    resp_o = RESP_NAK;
      else                                      resp_o = RESP_DATA;
   end

   assign en_o      = en_q;
   assign lvl_sel_o = sel_q;
   assign mask_o    = mask_q;

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !done_i && !dis_pulse_o) |=> en_q);  // R4

endmodule

// File: rtl/usb_in_ep_flags.sv
module usb_in_ep_flags #(
   parameter int NF         = 6,
   parameter int FIFO_DEPTH = 32,
   parameter int LVL_W      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NF-1:0]    set_i,
   input  logic             clr_wr,
   input  logic [NF-1:0]    clr_bits,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             sel_full_i,
   output logic [NF-1:0]    flags_o,
   output logic             empty_o
);

   localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(FIFO_DEPTH / 2);

   logic [NF-1:0] flags_q;

   for (genvar i = 0; i < NF; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) flags_q[i] <= 1'b0;
         else        flags_q[i] <= set_i[i] | (flags_q[i] & ~(clr_wr & clr_bits[i]));
      end
   end

   logic lvl_zero;
   assign lvl_zero = (lvl_i == '0);

   if (FIFO_DEPTH > 1) begin : g_half
      assign empty_o = sel_full_i ? lvl_zero : (lvl_i <= HALF_LVL);
   end else begin : g_single
      logic unused_sel;
      assign unused_sel = sel_full_i;
      assign empty_o    = lvl_zero;
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/usb_in_ep_tracker.sv
module usb_in_ep_tracker
   import usb_in_ep_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int BYTE_W     = 7,
   parameter int PKT_W      = 2,
   parameter int PKT_LSB    = 19,
   parameter int FIFO_DEPTH = 32,
   parameter int LVL_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_stb,
   input  logic [BYTE_W-1:0] load_len,
   input  logic              sent_stb,
   input  logic [LVL_W-1:0]  fifo_lvl,
   input  logic              in_token,
   input  logic              tmo_evt,
   input  logic              bus_err_evt,
   output logic              ep_enabled,
   output logic [DATA_W-1:0] xfer_size_reg,
   output logic [STS_W-1:0]  int_status,
   output logic              int_line,
   output logic [1:0]        ep_resp
);

   if (PKT_LSB < BYTE_W || PKT_LSB + PKT_W > DATA_W) begin : g_bad_layout
      $error("size register fields overlap or exceed the data width");
   end
   if (LVL_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_lvl
      $error("fifo level width too small for the fifo depth");
   end
   if (STS_W > DATA_W) begin : g_bad_sts
      $error("status register wider than the data width");
   end

   logic unused_wr;
   assign unused_wr = ^{wr_data[DATA_W-1:PKT_LSB+PKT_W], wr_data[PKT_LSB-1:BYTE_W]};

   logic wr_ctrl, wr_size, wr_sts, wr_mask;
   assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_size = wr_en && (wr_addr == ADDR_SIZE);
   assign wr_sts  = wr_en && (wr_addr == ADDR_STS);
   assign wr_mask = wr_en && (wr_addr == ADDR_MASK);

   logic              en, done, lvl_sel, dis_pulse, nak_eff_pulse, fifo_empty;
   logic [BYTE_W-1:0] bytes;
   logic [PKT_W-1:0]  pkts;
   logic [STS_W-1:0]  mask;
   logic [NUM_FLAGS-1:0] flag_set, flags;
   ep_resp_e          resp;

   usb_in_ep_counters #(.BYTE_W(BYTE_W), .PKT_W(PKT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_load  (wr_size),
      .sw_bytes (wr_data[BYTE_W-1:0]),
      .sw_pkts  (wr_data[PKT_LSB +: PKT_W]),
      .en_i     (en),
      .load_stb (load_stb),
      .load_len (load_len),
      .sent_stb (sent_stb),
      .bytes_o  (bytes),
      .pkts_o   (pkts),
      .done_o   (done)
   );

   usb_in_ep_ctrl #(.SW(STS_W)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .ctrl_wr         (wr_ctrl),
      .ctrl_bits       (wr_data[CTRL_W-1:0]),
      .mask_wr         (wr_mask),
      .mask_bits       (wr_data[STS_W-1:0]),
      .done_i          (done),
      .pkt_zero_i      (pkts == '0),
      .en_o            (en),
      .lvl_sel_o       (lvl_sel),
      .dis_pulse_o     (dis_pulse),
      .nak_eff_pulse_o (nak_eff_pulse),
      .mask_o          (mask),
      .resp_o          (resp)
   );

   always_comb begin
      flag_set            = '0;
      flag_set[SB_DONE]   = done;
      flag_set[SB_DIS]    = dis_pulse;
      flag_set[SB_BUSERR] = bus_err_evt;
      flag_set[SB_TMO]    = tmo_evt;
      flag_set[SB_TKN]    = in_token && (fifo_lvl == '0);
      flag_set[SB_NAKEFF] = nak_eff_pulse;
   end

   usb_in_ep_flags #(.NF(NUM_FLAGS), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (flag_set),
      .clr_wr     (wr_sts),
      .clr_bits   (wr_data[NUM_FLAGS-1:0]),
      .lvl_i      (fifo_lvl),
      .sel_full_i (lvl_sel),
      .flags_o    (flags),
      .empty_o    (fifo_empty)
   );

   always_comb begin
      xfer_size_reg                    = '0;
      xfer_size_reg[BYTE_W-1:0]        = bytes;
      xfer_size_reg[PKT_LSB +: PKT_W]  = pkts;
   end

   assign int_status = {fifo_empty, flags};
   assign int_line   = |(int_status & mask);
   assign ep_enabled = en;
   assign ep_resp    = resp;

   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!ep_enabled && int_status[SB_DONE]));  // R5

   AST_TOKEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_token && fifo_lvl == '0) |=> int_status[SB_TKN]);  // R8

   AST_NO_DATA_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_enabled && pkts == '0) |-> ep_resp != RESP_DATA);  // R6

endmodule

// File: tb/usb_in_ep_tracker_tb.sv
module usb_in_ep_tracker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        load_stb = 1'b0;
   logic [6:0]  load_len = '0;
   logic        sent_stb = 1'b0;
   logic [5:0]  fifo_lvl = '0;
   logic        in_token = 1'b0;
   logic        tmo_evt = 1'b0;
   logic        bus_err_evt = 1'b0;
   logic        ep_enabled;
   logic [31:0] xfer_size_reg;
   logic [6:0]  int_status;
   logic        int_line;
   logic [1:0]  ep_resp;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   usb_in_ep_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load_stb(load_stb), .load_len(load_len), .sent_stb(sent_stb), .fifo_lvl(fifo_lvl),
      .in_token(in_token), .tmo_evt(tmo_evt), .bus_err_evt(bus_err_evt),
      .ep_enabled(ep_enabled), .xfer_size_reg(xfer_size_reg), .int_status(int_status),
      .int_line(int_line), .ep_resp(ep_resp)
   );

   // op(1) len(7) expected bytes(7) expected packets(2)
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 7'd64, 7'd36, 2'd3},
      {1'b1, 7'd0,  7'd36, 2'd2},
      {1'b0, 7'd40, 7'd0,  2'd2},
      {1'b1, 7'd0,  7'd0,  2'd1},
      {1'b0, 7'd10, 7'd0,  2'd1},
      {1'b1, 7'd0,  7'd0,  2'd0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_load(input logic [6:0] len);
      @(negedge clk);
      load_stb = 1'b1; load_len = len;
      @(negedge clk);
      load_stb = 1'b0; load_len = '0;
   endtask

   task automatic do_send();
      @(negedge clk);
      sent_stb = 1'b1;
      @(negedge clk);
      sent_stb = 1'b0;
   endtask

   function automatic logic [31:0] size_word(input int b, input int p);
      return (32'(p) << 19) | 32'(b);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset size", xfer_size_reg, 32'h0);
      check("R7 reset status", 32'(int_status), 32'h40);
      check("R12 reset irq", 32'(int_line), 32'h0);
      check("R10 reset resp", 32'(ep_resp), 32'h2);
      check("R4 reset enable", 32'(ep_enabled), 32'h0);

      reg_wr(2'd1, 32'hFFFF_FFFF);
      check("R1 field layout", xfer_size_reg, 32'h0018_007F);

      // table-driven transfer: 100 bytes, 3 packets
      reg_wr(2'd1, size_word(100, 3));
      reg_wr(2'd0, 32'h1);
      check("R4 enable set", 32'(ep_enabled), 32'h1);
      check("R10 data resp", 32'(ep_resp), 32'h1);
      for (int i = 0; i < 6; i++) begin
         if (VEC[i][16]) do_send();
         else            do_load(VEC[i][15:9]);
         check("R2 byte total", 32'(xfer_size_reg[6:0]), 32'(VEC[i][8:2]));
         check("R3 packet total", 32'(xfer_size_reg[20:19]), 32'(VEC[i][1:0]));
         check("R4 still enabled", 32'(ep_enabled), 32'h1);
      end
      @(negedge clk);
      check("R5 enable cleared", 32'(ep_enabled), 32'h0);
      check("R5 done flag", 32'(int_status[0]), 32'h1);
      check("R12 masked off", 32'(int_line), 32'h0);
      reg_wr(2'd3, 32'h1);
      check("R12 irq on mask", 32'(int_line), 32'h1);
      reg_wr(2'd2, 32'h1);
      check("R11 w1c done", 32'(int_status[0]), 32'h0);
      check("R12 irq after clear", 32'(int_line), 32'h0);

      // ownership while enabled
      reg_wr(2'd1, size_word(50, 2));
      reg_wr(2'd0, 32'h1);
      reg_wr(2'd1, size_word(5, 1));
      check("R4 size write ignored", xfer_size_reg, size_word(50, 2));
      reg_wr(2'd0, 32'h0);
      check("R4 enable not cleared", 32'(ep_enabled), 32'h1);
      reg_wr(2'd0, 32'h10);
      check("R9 disable request", 32'(ep_enabled), 32'h0);
      check("R9 disabled flag", 32'(int_status[1]), 32'h1);
      reg_wr(2'd2, 32'h2);

      // packets exhausted before bytes
      reg_wr(2'd1, size_word(20, 1));
      reg_wr(2'd0, 32'h1);
      do_send();
      repeat (3) @(negedge clk);
      check("R6 nak with bytes left", 32'(ep_resp), 32'h2);
      check("R6 stays enabled", 32'(ep_enabled), 32'h1);
      check("R6 not done", 32'(int_status[0]), 32'h0);
      do_load(7'd20);
      @(negedge clk);
      check("R6 completes after bytes", 32'(ep_enabled), 32'h0);
      check("R5 done after both", 32'(int_status[0]), 32'h1);
      reg_wr(2'd2, 32'h1);

      // FIFO-empty thresholds
      fifo_lvl = 6'd16; @(negedge clk);
      check("R7 half level", 32'(int_status[6]), 32'h1);
      fifo_lvl = 6'd17; @(negedge clk);
      check("R7 above half", 32'(int_status[6]), 32'h0);
      reg_wr(2'd0, 32'h20);
      fifo_lvl = 6'd1; @(negedge clk);
      check("R7 full-empty mode level 1", 32'(int_status[6]), 32'h0);
      fifo_lvl = 6'd0; @(negedge clk);
      check("R7 full-empty mode level 0", 32'(int_status[6]), 32'h1);

      // token on empty FIFO
      fifo_lvl = 6'd5;
      @(negedge clk); in_token = 1'b1; @(negedge clk); in_token = 1'b0;
      check("R8 token with data", 32'(int_status[4]), 32'h0);
      fifo_lvl = 6'd0;
      @(negedge clk); in_token = 1'b1; @(negedge clk); in_token = 1'b0;
      check("R8 token while empty", 32'(int_status[4]), 32'h1);

      // timeout, bus error, set-wins clear
      @(negedge clk); tmo_evt = 1'b1; @(negedge clk); tmo_evt = 1'b0;
      check("R9 timeout flag", 32'(int_status[3]), 32'h1);
      @(negedge clk); bus_err_evt = 1'b1; @(negedge clk); bus_err_evt = 1'b0;
      check("R9 bus error flag", 32'(int_status[2]), 32'h1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h4; bus_err_evt = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; bus_err_evt = 1'b0;
      check("R11 set beats clear", 32'(int_status[2]), 32'h1);
      check("R11 others untouched", 32'(int_status[3]), 32'h1);
      reg_wr(2'd2, 32'h8);
      check("R11 clear timeout", 32'(int_status[3]), 32'h0);
      check("R11 bus error kept", 32'(int_status[2]), 32'h1);

      // NAK and stall
      reg_wr(2'd1, size_word(10, 1));
      reg_wr(2'd0, 32'h1);
      check("R10 data before nak", 32'(ep_resp), 32'h1);
      reg_wr(2'd0, 32'h2);
      check("R10 nak resp", 32'(ep_resp), 32'h2);
      check("R10 nak flag not yet", 32'(int_status[5]), 32'h0);
      @(negedge clk);
      check("R10 nak effective", 32'(int_status[5]), 32'h1);
      reg_wr(2'd0, 32'h6);
      check("R10 stall over nak", 32'(ep_resp), 32'h3);
      reg_wr(2'd0, 32'h8);
      check("R10 back to data", 32'(ep_resp), 32'h1);
      reg_wr(2'd3, 32'h20);
      check("R12 nak flag irq", 32'(int_line), 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule